// File: doc/BRIEF.md
# Two-Source Programmable Interrupt Controller

This block collects interrupt requests from two sources, a finger-detect comparator (source 0) and an external interrupt pin (source 1). It turns them into one active-low, open-drain interrupt request. Each source has its own configuration: enable, mask, trigger type (edge or level) and polarity. Because polarity is set per source, one source can be set to catch the finger arriving and later the finger leaving.

Both raw inputs are first brought into the clock domain through a two-stage synchronizer. A qualified event then latches a sticky pending flag. Software clears a pending flag by writing 1 to it. Masking and disabling act at different points:

- A masked source never reaches its pending flag.
- A disabled source still latches its pending flag, but it is kept off the interrupt pin.

Software reaches the block through a one-bit-address register port. Address 0 is the control register and address 1 is the status register. Read data is combinational from the address. A write takes effect at the clock edge where `reg_wr` is high. The interrupt output `irq_pull` is 1 when the pad must be driven low. When it is 0, the pad is released (high impedance).

Top module: `irqc_top`

## Requirements
- R1: Synchronous active-high reset clears the control register, both pending flags and the synchronizer state. After reset `irq_pull` is 0.
- R2: Control register (address 0) fields:
  - bit 7: polarity of source 1; bit 6: polarity of source 0.
  - bit 5: trigger of source 1; bit 4: trigger of source 0.
  - bit 3: mask of source 1; bit 2: mask of source 0.
  - bit 1: enable of source 1; bit 0: enable of source 0.
  - The register reads back the value last written.
- R3: With trigger bit 0 (edge), a source with polarity 1 sets its pending flag on a 0-to-1 change of its synchronized input. With polarity 0 it sets the flag on a 1-to-0 change. The opposite edge has no effect. The flag becomes visible three clock edges after the input change is first sampled.
- R4: With trigger bit 1 (level), a source sets its pending flag on every cycle its synchronized input equals its polarity bit. If the input is still active when the flag is cleared, the flag is set again.
- R5: A source whose mask bit is 1 cannot set its pending flag. Setting the mask bit does not clear a flag that is already set.
- R6: A source whose enable bit is 0 still sets its pending flag, but does not cause `irq_pull`.
- R7: Status register (address 1) fields:
  - bits 3 and 2: synchronized live levels of source 1 and source 0, regardless of any control setting.
  - bits 1 and 0: pending flags of source 1 and source 0.
  - bits 7 to 4: read as 0.
- R8: Writing 1 to status bit 0 or bit 1 clears that pending flag. Writing 0 to a pending bit leaves it unchanged.
- R9: If a qualified event and a clear of the same source fall on the same clock edge, the pending flag stays set.
- R10: `irq_pull` is 1 exactly when some source has both its pending flag and its enable bit set.
- R11: Writes to status bits 7 to 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_raw | input | 2 | Raw sources: bit 0 finger detect, bit 1 external pin (asynchronous) |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_pull | output | 1 | 1 drives the active-low interrupt pad low; 0 releases it |

## Verification
The assertions assume that `reg_wr` is a clean one-cycle-per-write strobe. They also assume that the register inputs are stable around the clock edge. The bench keeps to this by changing every input a quarter period after the rising edge. The raw sources are treated as arbitrary and may toggle on any cycle. The stimulus combines directed sequences with random ones:
- The directed sequences place an event and a clear on the same edge, and toggle the mask while a flag is pending.
- The random sequences toggle the sources and write both registers freely, so edge, level, mask and enable settings all change while events are in flight.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC   = 2;
    localparam int DATA_W    = 8;
    localparam int SYNC_DEPTH = 2;

    // Field groups in the control register; each group holds one bit per source.
    localparam int FLD_EN   = 0;
    localparam int FLD_MASK = 1;
    localparam int FLD_TRIG = 2;
    localparam int FLD_POL  = 3;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int STAT_PEND_LSB = 0;
    localparam int STAT_LIVE_LSB = NUM_SRC;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic pol;
        logic trig;
        logic mask;
        logic en;
    } src_cfg_t;

    typedef src_cfg_t [NUM_SRC-1:0] cfg_vec_t;

    function automatic int fld_bit(input int fld, input int src);
        return fld * NUM_SRC + src;
    endfunction

    function automatic cfg_vec_t ctrl_decode(input logic [DATA_W-1:0] c);
        cfg_vec_t v;
        for (int i = 0; i < NUM_SRC; i++) begin
            v[i].en   = c[fld_bit(FLD_EN, i)];
            v[i].mask = c[fld_bit(FLD_MASK, i)];
            v[i].trig = c[fld_bit(FLD_TRIG, i)];
            v[i].pol  = c[fld_bit(FLD_POL, i)];
        end
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] stat_encode(input logic [NUM_SRC-1:0] live,
                                                      input logic [NUM_SRC-1:0] pend);
        logic [DATA_W-1:0] r;
        r = '0;
        r[STAT_PEND_LSB +: NUM_SRC] = pend;
        r[STAT_LIVE_LSB +: NUM_SRC] = live;
        return r;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  src_cfg_t cfg,
    output logic     evt
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        case (trig_e'(cfg.trig))
            TRIG_EDGE:  evt = cfg.pol ? rise : fall;
            TRIG_LEVEL: evt = (lvl == cfg.pol);
            default:    evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend_q
);
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] pend_d;

    // Set takes priority over clear in the same cycle.
    assign set_v  = evt & ~mask;
    assign pend_d = (pend_q & ~clr) | set_v;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               addr,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] live,
    input  logic [NUM_SRC-1:0] pend,
    output logic [DATA_W-1:0]  ctrl_q,
    output logic [NUM_SRC-1:0] clr,
    output logic [DATA_W-1:0]  rdata
);
    logic wr_ctrl, wr_stat;

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign wr_stat = wr && (addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata;
    end

    assign clr = wr_stat ? wdata[STAT_PEND_LSB +: NUM_SRC] : '0;

    always_comb begin
        if (addr == ADDR_CTRL) rdata = ctrl_q;
        else                   rdata = stat_encode(live, pend);
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_raw,
    input  logic               reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_pull
);
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_v;
    logic [NUM_SRC-1:0] en_v;
    logic [DATA_W-1:0]  ctrl_q;
    cfg_vec_t           cfg;

    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_raw),
        .q   (live)
    );

    irqc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .live   (live),
        .pend   (pend_q),
        .ctrl_q (ctrl_q),
        .clr    (clr),
        .rdata  (reg_rdata)
    );

    assign cfg = ctrl_decode(ctrl_q);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irqc_detect u_det (
            .clk (clk),
            .rst (rst),
            .lvl (live[i]),
            .cfg (cfg[i]),
            .evt (evt[i])
        );
        assign mask_v[i] = cfg[i].mask;
        assign en_v[i]   = cfg[i].en;
    end

    irqc_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .mask   (mask_v),
        .clr    (clr),
        .pend_q (pend_q)
    );

    assign irq_pull = |(pend_q & en_v);
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [DATA_W-1:0]  ctrl,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] clr,
    input logic               irq_pull
);
    logic [NUM_SRC-1:0] en_bits;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        assign en_bits[i] = ctrl[fld_bit(FLD_EN, i)];
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl == '0 && pend == '0 && !irq_pull));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (en_bits == '0) |-> !irq_pull);

    assert_pull_needs_pending_R10: assert property (@(posedge clk) disable iff (rst)
        irq_pull |-> (pend != '0));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
            (!pend[i] && ctrl[fld_bit(FLD_MASK, i)]) |=> !pend[i]);

        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (pend[i] && !clr[i]) |=> pend[i]);

        assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
            (evt[i] && !ctrl[fld_bit(FLD_MASK, i)]) |=> pend[i]);
    end
endmodule

bind irqc_top irqc_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl_q),
    .pend     (pend_q),
    .evt      (evt),
    .clr      (clr),
    .irq_pull (irq_pull)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
    localparam int CLK_PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_raw = '0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_pull;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top uut (
        .clk       (clk),
        .rst       (rst),
        .src_raw   (src_raw),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_pull  (irq_pull)
    );

    // Behavioural reference: a two-deep history per source plus flags.
    int m_s1 [2];
    int m_s2 [2];
    int m_prev [2];
    int m_pend [2];
    int m_ctrl;

    always @(posedge clk) begin
        int np [2];
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
            end
            m_ctrl = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                int msk, trg, pol, ev, cl;
                msk = (m_ctrl >> (2 + i)) & 1;
                trg = (m_ctrl >> (4 + i)) & 1;
                pol = (m_ctrl >> (6 + i)) & 1;
                if (trg == 1) ev = (m_s2[i] == pol);
                else if (pol == 1) ev = (m_s2[i] == 1 && m_prev[i] == 0);
                else ev = (m_s2[i] == 0 && m_prev[i] == 1);
                cl = (reg_wr && reg_addr == 1'b1 && reg_wdata[i]) ? 1 : 0;
                np[i] = ((m_pend[i] != 0 && cl == 0) || (ev != 0 && msk == 0)) ? 1 : 0;
            end
            for (int i = 0; i < 2; i++) begin
                m_pend[i] = np[i];
                m_prev[i] = m_s2[i];
                m_s2[i]   = m_s1[i];
                m_s1[i]   = src_raw[i];
            end
            if (reg_wr && reg_addr == 1'b0) m_ctrl = reg_wdata;
        end
    end

    function automatic int exp_stat();
        return (m_s2[1] << 3) | (m_s2[0] << 2) | (m_pend[1] << 1) | m_pend[0];
    endfunction

    function automatic int exp_irq();
        return ((m_pend[0] != 0 && (m_ctrl & 1) != 0) ||
                (m_pend[1] != 0 && (m_ctrl & 2) != 0)) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the rising edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 irq_pull", int'(irq_pull), exp_irq());
            if (reg_addr == 1'b0) chk("R2 control readback", int'(reg_rdata), m_ctrl);
            else                  chk("R7 status readback", int'(reg_rdata), exp_stat());
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    int v;

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        ticks(3);
        rst = 1'b0;
        tick();

        // R1: reset state
        rd(1'b0, v); chk("R1 control after reset", v, 0);
        rd(1'b1, v); chk("R1 pending after reset", v & 3, 0);
        chk("R1 irq after reset", int'(irq_pull), 0);

        // R2: source 0 rising edge, enabled
        wr(1'b0, 8'h41);
        rd(1'b0, v); chk("R2 control write", v, 8'h41);

        // R3: rising edge sets pending after three edges
        src_raw[0] = 1'b1;
        ticks(2);
        rd(1'b1, v); chk("R3 not yet pending", v & 1, 0);
        tick();
        rd(1'b1, v); chk("R3 rising edge pending", v & 1, 1);
        chk("R7 live bit source 0", (v >> 2) & 1, 1);
        chk("R10 irq with enabled pending", int'(irq_pull), 1);

        // R8: write 0 keeps, write 1 clears
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R8 write zero keeps", v & 1, 1);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R8 write one clears", v & 1, 0);
        chk("R10 irq released", int'(irq_pull), 0);

        // R3: opposite edge ignored
        src_raw[0] = 1'b0;
        ticks(4);
        rd(1'b1, v); chk("R3 falling ignored at pol 1", v & 1, 0);

        // R3: falling polarity
        wr(1'b0, 8'h01);
        src_raw[0] = 1'b1; ticks(4);
        rd(1'b1, v); chk("R3 rising ignored at pol 0", v & 1, 0);
        src_raw[0] = 1'b0; ticks(4);
        rd(1'b1, v); chk("R3 falling edge pending", v & 1, 1);
        wr(1'b1, 8'h01);

        // R4: level trigger re-sets while active
        wr(1'b0, 8'h51);
        src_raw[0] = 1'b1; ticks(4);
        rd(1'b1, v); chk("R4 level pending", v & 1, 1);
        wr(1'b1, 8'h01); tick();
        rd(1'b1, v); chk("R4 level re-set after clear", v & 1, 1);
        src_raw[0] = 1'b0; ticks(4);
        wr(1'b1, 8'h01); tick();
        rd(1'b1, v); chk("R4 inactive level stays clear", v & 1, 0);

        // R5: masked source cannot set
        wr(1'b0, 8'h45);
        src_raw[0] = 1'b1; ticks(4);
        rd(1'b1, v); chk("R5 masked edge ignored", v & 1, 0);
        wr(1'b0, 8'h41);
        src_raw[0] = 1'b0; ticks(4);
        src_raw[0] = 1'b1; ticks(4);
        rd(1'b1, v); chk("R5 unmasked edge pending", v & 1, 1);
        wr(1'b0, 8'h45); ticks(2);
        rd(1'b1, v); chk("R5 mask keeps pending", v & 1, 1);
        wr(1'b1, 8'h01);

        // R6: disabled source 1 still pends, no output
        wr(1'b0, 8'h80);
        src_raw[1] = 1'b1; ticks(4);
        rd(1'b1, v); chk("R6 disabled pending set", (v >> 1) & 1, 1);
        chk("R6 disabled no irq", int'(irq_pull), 0);
        wr(1'b0, 8'h82);
        chk("R10 enable raises irq", int'(irq_pull), 1);
        wr(1'b1, 8'h02);
        chk("R10 clear drops irq", int'(irq_pull), 0);

        // R11: upper status bits ignore writes
        wr(1'b1, 8'hF0);
        rd(1'b1, v);
        chk("R11 upper status bits zero", v >> 4, 0);
        chk("R11 pending untouched", v & 3, 0);

        // R9: event and clear on the same edge
        wr(1'b0, 8'h41);
        src_raw[0] = 1'b0; ticks(4);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R9 precondition clear", v & 1, 0);
        src_raw[0] = 1'b1;
        ticks(2);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R9 event beats clear", v & 1, 1);

        // Random phase, compared against the reference every cycle
        for (int n = 0; n < 4000; n++) begin
            src_raw = 2'($urandom);
            reg_addr = 1'($urandom);
            if ($urandom_range(0, 9) < 2) begin
                reg_wdata = 8'($urandom);
                reg_wr = 1'b1;
            end else begin
                reg_wr = 1'b0;
            end
            tick();
        end
        reg_wr = 1'b0;
        ticks(2);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule